// File: doc/BRIEF.md
# SPI Slave Shift Engine with Frame-Abort Flag

This block is the receive and transmit core of an SPI slave port. An external master supplies the serial clock, the data input and an active-low select. The engine moves 8-bit characters most significant bit first in both directions, under any of the four combinations of clock idle level (CPOL) and sampling phase (CPHA). The serial inputs are brought into the system clock domain through two-flop synchronizers, and clock edges are found by comparing successive synchronized samples. The engine therefore follows the rate of the master's clock, up to a limit set by the system clock: each SCK level has to last at least four system clock periods.

Each completed character appears on `rx_data` with a one-cycle `rx_valid` strobe. The byte to send is taken from `tx_data` when select asserts and again at the start of every following character, and a one-cycle `tx_load` pulse marks each capture so the surrounding logic can present the next byte. If the master releases select part way through a character, a sticky `abort_err` flag is set. The flag raises no interrupt. It stays set until software drops the enable bit, and dropping the enable bit also returns the shift logic to its idle state.

The format bits are captured only while the engine is disabled, so a format change while enabled cannot upset a transfer in progress.

Top module: `spi_frame_slave`

## Requirements
- R1: In all four formats the engine shifts 8 MOSI bits into a character, MSB first. The leading edge is the SCK transition away from the idle level `cfg_cpol`. With CPHA=0 MOSI is sampled on leading edges; with CPHA=1 it is sampled on trailing edges. The character appears on `rx_data`.
- R2: MISO carries the captured `tx_data` MSB first. With CPHA=0 the next bit is driven on trailing edges. With CPHA=1 each bit is driven on the leading edge of its bit period, so a master sampling on the opposite edge reads the byte intact.
- R3: With CPHA=0 the MSB of the captured byte is on `miso` within three system clock cycles after the synchronized select assertion, before any SCK edge.
- R4: `rx_valid` is a single-cycle pulse, given once for every complete 8-bit character. A character cut short by select release gives no pulse.
- R5: Releasing select after 1 to 7 bits of the current character have been sampled sets `abort_err`.
- R6: `abort_err` stays set through later transfers while `enable` is high. It clears only in the cycle after `enable` is low, which also resets the bit counter and shift registers.
- R7: `cfg_cpol` and `cfg_cpha` are captured only while `enable` is low. Changes made while `enable` is high have no effect on the transfer format.
- R8: `miso_oe` is high only while the engine is enabled and the synchronized select is asserted, and it is low otherwise.
- R9: `tx_load` pulses for one cycle at each capture of `tx_data`: once at select assertion and once on the drive edge after each completed character. An n-character burst therefore gives n+1 pulses with CPHA=0 and n pulses with CPHA=1.
- R10: Releasing select exactly on a character boundary leaves `abort_err` clear.
- R11: While `enable` is low, SCK and select activity produce no `rx_valid` and no `tx_load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable bit; low clears the error flag and the shift state |
| cfg_cpol | input | 1 | Clock idle level, captured while disabled |
| cfg_cpha | input | 1 | Sample on first (0) or second (1) edge, captured while disabled |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| sel_n | input | 1 | Active-low slave select |
| tx_data | input | 8 | Byte to transmit, captured when `tx_load` pulses |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` |
| rx_data | output | 8 | Last complete received character |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is captured |
| abort_err | output | 1 | Sticky flag for select released mid-character |

## Verification
The bench targets select release after one bit and after five bits. A design that counts bits wrongly or compares against the wrong count would miss the flag, or would also flag the clean boundary release that R10 requires to stay quiet. It also changes the format pins while enabled: an engine that tracks the pins directly flips its edge choice mid-session and returns shifted or inverted bytes. With CPHA=0 it checks MISO before the first SCK edge, which catches a design that loads the byte on an edge instead of at select. Multi-byte bursts in every format catch a reload that lands on the wrong edge; that fault would repeat the previous byte or drop the second character's MSB.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;

    // Transfer format captured while the engine is disabled.
    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi_fmt_t;

    // Transition away from the idle level.
    function automatic logic is_lead(input spi_fmt_t f, input logic prev, input logic cur);
        return (prev == f.cpol) && (cur != f.cpol);
    endfunction

    // Transition back to the idle level.
    function automatic logic is_trail(input spi_fmt_t f, input logic prev, input logic cur);
        return (prev != f.cpol) && (cur == f.cpol);
    endfunction

endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
module spi_slv_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stg_d[g] = din;
        end else begin : g_chain
            assign stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
`timescale 1ns/1ps
module spi_slv_edge
    import spi_slv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_s,
    input  spi_fmt_t fmt,
    output logic     sample_p,
    output logic     drive_p
);

    typedef struct packed {
        logic sck_prev;
    } edge_st_t;

    edge_st_t state_d, state_q;
    logic     lead, trail;

    always_comb begin
        state_d          = state_q;
        state_d.sck_prev = sck_s;
        lead             = is_lead(fmt, state_q.sck_prev, sck_s);
        trail            = is_trail(fmt, state_q.sck_prev, sck_s);
        sample_p         = fmt.cpha ? trail : lead;
        drive_p          = fmt.cpha ? lead  : trail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Two sampling edges need a drive edge between them.
    assert_sample_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_p |=> !sample_p);

    assert_drive_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_p |=> !drive_p);

endmodule

// File: rtl/spi_slv_core.sv
`timescale 1ns/1ps
module spi_slv_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sel_s,
    input  logic          mosi_s,
    input  logic          sample_p,
    input  logic          drive_p,
    input  logic [DW-1:0] tx_data,
    output logic          miso,
    output logic          miso_oe,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          tx_load,
    output logic          abort_err
);

    localparam int          CW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] rx_sh;
        logic [DW-1:0] tx_sh;
        logic [DW-1:0] rx_byte;
        logic          rx_vld;
        logic          tx_ld;
        logic          pend;
        logic          err;
        logic          sel_prev;
        logic          oe;
    } core_st_t;

    core_st_t      state_d, state_q;
    logic [DW-1:0] rx_next;

    always_comb begin
        state_d          = state_q;
        state_d.rx_vld   = 1'b0;
        state_d.tx_ld    = 1'b0;
        state_d.sel_prev = sel_s;
        state_d.oe       = enable && !sel_s;
        rx_next          = {state_q.rx_sh[DW-2:0], mosi_s};

        if (!enable) begin
            // Disable: clear error and shift state.
            state_d.cnt   = '0;
            state_d.pend  = 1'b0;
            state_d.err   = 1'b0;
            state_d.rx_sh = '0;
            state_d.tx_sh = '0;
        end else if (sel_s) begin
            // Deselected: a partial character marks an abort.
            state_d.cnt  = '0;
            state_d.pend = 1'b0;
            if (!state_q.sel_prev && state_q.cnt != '0) state_d.err = 1'b1;
        end else if (state_q.sel_prev) begin
            // Select just asserted: first byte goes straight onto MISO.
            state_d.tx_sh = tx_data;
            state_d.tx_ld = 1'b1;
            state_d.cnt   = '0;
            state_d.pend  = 1'b0;
            state_d.rx_sh = '0;
        end else begin
            if (sample_p) begin
                state_d.rx_sh = rx_next;
                if (state_q.cnt == LAST) begin
                    state_d.rx_byte = rx_next;
                    state_d.rx_vld  = 1'b1;
                    state_d.cnt     = '0;
                    state_d.pend    = 1'b1;
                end else begin
                    state_d.cnt = state_q.cnt + CW'(1);
                end
            end
            if (drive_p) begin
                if (state_q.pend) begin
                    state_d.tx_sh = tx_data;
                    state_d.tx_ld = 1'b1;
                    state_d.pend  = 1'b0;
                end else if (state_q.cnt != '0) begin
                    state_d.tx_sh = {state_q.tx_sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.sel_prev <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign miso      = state_q.tx_sh[DW-1];
    assign miso_oe   = state_q.oe;
    assign rx_data   = state_q.rx_byte;
    assign rx_valid  = state_q.rx_vld;
    assign tx_load   = state_q.tx_ld;
    assign abort_err = state_q.err;

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rx_vld |=> !state_q.rx_vld);

    assert_valid_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rx_vld |-> (state_q.cnt == '0 && state_q.pend));

    assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.err) |-> ($past(sel_s) && !$past(sel_s, 2)));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.err && enable) |=> state_q.err);

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !state_q.err);

    assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || sel_s) |=> !state_q.oe);

    assert_load_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.tx_ld |=> !state_q.tx_ld);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!state_q.rx_vld && !state_q.tx_ld));

endmodule

// File: rtl/spi_frame_slave.sv
`timescale 1ns/1ps
module spi_frame_slave
    import spi_slv_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          sck,
    input  logic          mosi,
    input  logic          sel_n,
    input  logic [DW-1:0] tx_data,
    output logic          miso,
    output logic          miso_oe,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          tx_load,
    output logic          abort_err
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, syn_out;
    logic             sck_s, mosi_s, sel_s;
    logic             sample_p, drive_p;
    spi_fmt_t         fmt_d, fmt_q;

    assign raw_in = {sck, mosi, sel_n};

    spi_slv_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (syn_out)
    );

    assign {sck_s, mosi_s, sel_s} = syn_out;

    // Format follows the pins only while disabled.
    always_comb begin
        fmt_d = fmt_q;
        if (!enable) fmt_d = '{cpol: cfg_cpol, cpha: cfg_cpha};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fmt_q <= '0;
        else        fmt_q <= fmt_d;
    end

    spi_slv_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .fmt      (fmt_q),
        .sample_p (sample_p),
        .drive_p  (drive_p)
    );

    spi_slv_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sel_s     (sel_s),
        .mosi_s    (mosi_s),
        .sample_p  (sample_p),
        .drive_p   (drive_p),
        .tx_data   (tx_data),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .tx_load   (tx_load),
        .abort_err (abort_err)
    );

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> $stable(fmt_q));

endmodule

// File: tb/sim_spi_frame_slave.sv
`timescale 1ns/1ps
module sim_spi_frame_slave;

    localparam int H        = 4;   // SCK half period in system clocks
    localparam int SEL_WAIT = 6;   // clocks from select to first SCK edge

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cpha = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       sel_n = 1'b1;
    logic [7:0] tx_data;
    logic       miso, miso_oe, rx_valid, tx_load, abort_err;
    logic [7:0] rx_data;

    logic [7:0] slv_pat [64];
    logic [7:0] rx_got  [64];
    int         rx_cnt = 0;
    int         tx_idx = 0;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #2.5 clk = ~clk;

    assign tx_data = slv_pat[tx_idx];

    spi_frame_slave u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .sck(sck), .mosi(mosi), .sel_n(sel_n),
        .tx_data(tx_data), .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data),
        .rx_valid(rx_valid), .tx_load(tx_load), .abort_err(abort_err)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_got[rx_cnt % 64] = rx_data;
            rx_cnt++;
        end
        if (tx_load) tx_idx = (tx_idx + 1) % 64;
    end

    function automatic int exp_loads(input logic ph, input int n);
        return ph ? n : n + 1;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic set_mode(input logic cp, input logic ph);
        enable   = 1'b0;
        cfg_cpol = cp;
        cfg_cpha = ph;
        sck      = cp;
        wait_clk(4);
        enable = 1'b1;
        wait_clk(4);
    endtask

    // Master side of nb bits, MSB first; returns bits read from MISO.
    task automatic do_bits(input logic cp, input logic ph, input logic [7:0] mo,
                           input int nb, output logic [7:0] mi);
        mi = '0;
        for (int b = 7; b >= 8 - nb; b--) begin
            if (!ph) begin
                mosi = mo[b];
                wait_clk(H);
                mi[b] = miso;
                sck   = ~cp;
                wait_clk(H);
                sck = cp;
            end else begin
                wait_clk(H);
                sck  = ~cp;
                mosi = mo[b];
                wait_clk(H);
                mi[b] = miso;
                sck   = cp;
            end
        end
    endtask

    task automatic burst(input logic cp, input logic ph, input int nbytes,
                         input int extra_bits, input bit en_exp);
        int         rb, tb;
        logic [7:0] mb [4];
        logic [7:0] mi [4];
        rb = rx_cnt;
        tb = tx_idx;
        for (int i = 0; i < 4; i++) begin
            mb[i] = 8'($urandom);
            mi[i] = '0;
        end
        sel_n = 1'b0;
        wait_clk(SEL_WAIT);
        check(miso_oe == en_exp, "R8 oe while selected", int'(miso_oe), int'(en_exp));
        if (en_exp && !ph)
            check(miso == slv_pat[tb][7], "R3 first bit before SCK", int'(miso), int'(slv_pat[tb][7]));
        for (int i = 0; i < nbytes; i++) do_bits(cp, ph, mb[i], 8, mi[i]);
        if (extra_bits > 0) do_bits(cp, ph, mb[nbytes], extra_bits, mi[nbytes]);
        wait_clk(H);
        sel_n = 1'b1;
        wait_clk(8);
        check(miso_oe == 1'b0, "R8 oe after release", int'(miso_oe), 0);
        if (en_exp) begin
            check(rx_cnt - rb == nbytes, "R4 valid pulse count", rx_cnt - rb, nbytes);
            for (int i = 0; i < nbytes; i++) begin
                check(rx_got[(rb + i) % 64] == mb[i], "R1 received byte",
                      int'(rx_got[(rb + i) % 64]), int'(mb[i]));
                check(mi[i] == slv_pat[(tb + i) % 64], "R2 MISO byte",
                      int'(mi[i]), int'(slv_pat[(tb + i) % 64]));
            end
            if (extra_bits == 0)
                check(((tx_idx - tb + 64) % 64) == exp_loads(ph, nbytes), "R9 load pulses",
                      (tx_idx - tb + 64) % 64, exp_loads(ph, nbytes));
        end else begin
            check(rx_cnt == rb, "R11 no valid while disabled", rx_cnt - rb, 0);
            check(tx_idx == tb, "R11 no load while disabled", tx_idx - tb, 0);
        end
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5A17C0DE);
        for (int i = 0; i < 64; i++) slv_pat[i] = 8'($urandom);
        wait_clk(5);
        check(miso_oe == 1'b0, "R8 reset oe", int'(miso_oe), 0);
        check(rx_valid == 1'b0, "R4 reset valid", int'(rx_valid), 0);
        check(abort_err == 1'b0, "R5 reset error", int'(abort_err), 0);
        rst_n = 1'b1;
        wait_clk(3);

        // All four formats, directed.
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            burst(m[1], m[0], 2, 0, 1'b1);
            check(abort_err == 1'b0, "R10 clean release", int'(abort_err), 0);
        end

        // Format pins changed while enabled must be ignored.
        set_mode(1'b0, 1'b0);
        cfg_cpol = 1'b1;
        cfg_cpha = 1'b1;
        wait_clk(4);
        burst(1'b0, 1'b0, 2, 0, 1'b1);
        check(abort_err == 1'b0, "R7 format held", int'(abort_err), 0);

        // Abort after five bits of the second character.
        set_mode(1'b1, 1'b0);
        burst(1'b1, 1'b0, 1, 5, 1'b1);
        check(abort_err == 1'b1, "R5 abort flagged", int'(abort_err), 1);
        burst(1'b1, 1'b0, 2, 0, 1'b1);
        check(abort_err == 1'b1, "R6 flag sticky", int'(abort_err), 1);
        enable = 1'b0;
        wait_clk(3);
        check(abort_err == 1'b0, "R6 cleared by disable", int'(abort_err), 0);

        // Abort after a single bit, CPHA=1.
        set_mode(1'b0, 1'b1);
        burst(1'b0, 1'b1, 0, 1, 1'b1);
        check(abort_err == 1'b1, "R5 one-bit abort", int'(abort_err), 1);

        // Disabled engine ignores traffic.
        enable = 1'b0;
        sck    = 1'b0;
        wait_clk(4);
        burst(1'b0, 1'b0, 1, 0, 1'b0);
        check(abort_err == 1'b0, "R11 disabled no error", int'(abort_err), 0);

        // Random formats and burst lengths.
        for (int k = 0; k < 10; k++) begin
            logic cp, ph;
            int   n;
            cp = 1'($urandom);
            ph = 1'($urandom);
            n  = 1 + int'($urandom % 3);
            set_mode(cp, ph);
            burst(cp, ph, n, 0, 1'b1);
            check(abort_err == 1'b0, "R10 random clean release", int'(abort_err), 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule